// File: doc/BRIEF.md
# Core Interval Timer

A down-counting interval timer for use inside a processor subsystem, reached over a plain word-addressed register bus. Software writes a starting count and an optional reload period, picks a prescale divisor, and then sets the power and run bits in the control word. While both bits are set, the counter steps down by one on every prescaled tick. When a step takes it to zero, the timer raises a sticky flag in the control word and drives a one-cycle pulse on its interrupt output.

With auto-reload selected, the expiring step loads the period value, so the timer fires again at a fixed interval. Without auto-reload, the counter rests at zero and the control bits stay as software left them. Turning the timer off only freezes the counter. It does not touch the flag and cannot withdraw a pulse that has already been sent.

Top module: `core_interval_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: The registers sit at byte offsets 0x0 (control), 0x4 (period), 0x8 (scale) and 0xC (count). A read returns its data on `bus_rdata` in the cycle after the request. The period register returns exactly the value written, whether the timer is stopped or running.
- R3: The counter changes only when control bit 0 (power) and control bit 1 (run) are both 1, or when software writes the count register.
- R4: With scale value N, the counter steps once every N+1 cycles. A count C that is started by a control write at clock edge 0 expires at edge C*(N+1).
- R5: Expiry is the step from 1 to 0. It sets control bit 3 (flag) and makes `irq` high for exactly one cycle, starting at the expiry edge.
- R6: When control bit 2 (auto-reload) is 1, the expiring step loads the period value, and the next expiry follows period*(N+1) cycles later. The control word then reads 0x0F.
- R7: When auto-reload is 0, the counter stays at 0 after expiry and gives no further pulses. The run bit stays at 1, so the control word reads 0x0B.
- R8: The flag is cleared by writing 1 to bit 3. Writing 0 to bit 3 leaves it unchanged. Writing 0 to the whole control word stops counting but keeps the flag. If an expiry and a clear happen in the same cycle, the set wins.
- R9: The count register can be written at any time, independent of the period. A write to it in the same cycle as a step takes priority and suppresses that expiry.
- R10: Offsets other than 0x0, 0x4, 0x8 and 0xC, including unaligned ones, read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered, valid the cycle after a read request |
| irq | output | 1 | One-cycle interrupt pulse on each expiry |

## Verification
The properties assume that the bus carries at most one access per cycle and that `bus_sel` is a defined level after reset. They also assume that the reload and expiry checks are judged against register values that were stable in the cycle before the pulse. The bench drives every access on the falling edge and holds it for exactly one rising edge, so each request is seen once. It waits for each expiry by counting whole cycles from the control write, and it reads the registers back only after the event it is checking.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned OFS_CTRL   = 0;
  localparam int unsigned OFS_PERIOD = 4;
  localparam int unsigned OFS_SCALE  = 8;
  localparam int unsigned OFS_COUNT  = 12;

  localparam int unsigned BIT_PWR    = 0;
  localparam int unsigned BIT_RUN    = 1;
  localparam int unsigned BIT_RELOAD = 2;
  localparam int unsigned BIT_FLAG   = 3;
  localparam int unsigned CTRL_W     = 4;

  typedef enum logic [2:0] {
    RS_NONE, RS_CTRL, RS_PERIOD, RS_SCALE, RS_COUNT
  } rsel_e;

  typedef struct packed {
    logic flag;
    logic reload;
    logic run;
    logic pwr;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         active,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] div_q;

  // >= keeps the divider sane if the limit shrinks mid-run
  assign tick = active && (div_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      div_q <= '0;
    end else if (tick) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + W'(1);
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         reload_en,
  input  logic [W-1:0] period,
  output logic [W-1:0] count_q,
  output logic         expire
);
  localparam logic [W-1:0] ONE = W'(1);

  logic at_one;
  assign at_one = (count_q == ONE);
  assign expire = tick && !load && at_one;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (load) begin
      count_q <= load_val;
    end else if (tick && (count_q != '0)) begin
      if (at_one) begin
        count_q <= reload_en ? period : '0;
      end else begin
        count_q <= count_q - ONE;
      end
    end
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] count_q,
  input  logic              expire,
  output ctrl_t             ctrl_q,
  output logic [DATA_W-1:0] period_q,
  output logic [DATA_W-1:0] scale_q,
  output logic              count_wr,
  output logic [DATA_W-1:0] rdata
);
  rsel_e             rsel;
  logic              wr, rd;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rsel = RS_NONE;
    if      (bus_addr == ADDR_W'(OFS_CTRL))   rsel = RS_CTRL;
    else if (bus_addr == ADDR_W'(OFS_PERIOD)) rsel = RS_PERIOD;
    else if (bus_addr == ADDR_W'(OFS_SCALE))  rsel = RS_SCALE;
    else if (bus_addr == ADDR_W'(OFS_COUNT))  rsel = RS_COUNT;
  end

  assign wr       = bus_sel && bus_we;
  assign rd       = bus_sel && !bus_we;
  assign count_wr = wr && (rsel == RS_COUNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      period_q <= '0;
      scale_q  <= '0;
    end else begin
      if (wr && rsel == RS_CTRL) begin
        ctrl_q.pwr    <= bus_wdata[BIT_PWR];
        ctrl_q.run    <= bus_wdata[BIT_RUN];
        ctrl_q.reload <= bus_wdata[BIT_RELOAD];
      end
      if (expire) begin
        ctrl_q.flag <= 1'b1;
      end else if (wr && rsel == RS_CTRL && bus_wdata[BIT_FLAG]) begin
        ctrl_q.flag <= 1'b0;
      end
      if (wr && rsel == RS_PERIOD) period_q <= bus_wdata;
      if (wr && rsel == RS_SCALE)  scale_q  <= bus_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (rsel)
      RS_CTRL:   rd_mux[CTRL_W-1:0] = ctrl_q;
      RS_PERIOD: rd_mux = period_q;
      RS_SCALE:  rd_mux = scale_q;
      RS_COUNT:  rd_mux = count_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)      rdata <= '0;
    else if (rd)  rdata <= rd_mux;
    else          rdata <= '0;
  end
endmodule

// File: rtl/core_interval_timer.sv
module core_interval_timer
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] period_q, scale_q, count_q;
  logic              count_wr, tick, expire, active;
  logic              ctrl_pwr, ctrl_run, ctrl_reload, ctrl_flag;

  assign ctrl_pwr    = ctrl_q.pwr;
  assign ctrl_run    = ctrl_q.run;
  assign ctrl_reload = ctrl_q.reload;
  assign ctrl_flag   = ctrl_q.flag;
  assign active      = ctrl_pwr && ctrl_run;

  tmr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .count_q(count_q),
    .expire(expire), .ctrl_q(ctrl_q), .period_q(period_q),
    .scale_q(scale_q), .count_wr(count_wr), .rdata(bus_rdata)
  );

  tmr_prescale #(.W(DATA_W)) u_pre (
    .clk(clk), .rst(rst), .active(active), .limit(scale_q), .tick(tick)
  );

  tmr_counter #(.W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .load(count_wr),
    .load_val(bus_wdata), .reload_en(ctrl_reload), .period(period_q),
    .count_q(count_q), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= expire;
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic              pwr,
  input logic              run,
  input logic              reload,
  input logic              flag,
  input logic [DATA_W-1:0] period,
  input logic [DATA_W-1:0] count
);
  logic cnt_write, unmapped;
  assign cnt_write = bus_sel && bus_we && (bus_addr == ADDR_W'(OFS_COUNT));
  assign unmapped  = !(bus_addr == ADDR_W'(OFS_CTRL)  || bus_addr == ADDR_W'(OFS_PERIOD) ||
                       bus_addr == ADDR_W'(OFS_SCALE) || bus_addr == ADDR_W'(OFS_COUNT));

  AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!(pwr && run) && !cnt_write) |=> $stable(count)); // R3
  AST_IRQ_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(pwr && run)); // R3
  AST_IRQ_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag); // R5
  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
    (irq && $past(reload)) |-> (count == $past(period))); // R6
  AST_ONESHOT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (irq && !$past(reload)) |-> (count == '0)); // R7
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(bus_sel && !bus_we && unmapped) |-> (bus_rdata == '0)); // R10
endmodule

bind core_interval_timer tmr_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq(irq),
  .pwr(ctrl_pwr), .run(ctrl_run), .reload(ctrl_reload), .flag(ctrl_flag),
  .period(period_q), .count(count_q)
);

// File: tb/core_interval_timer_bench.sv
module core_interval_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_sel = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  core_interval_timer #(.DATA_W(DW), .ADDR_W(AW)) u_core_interval_timer (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = AW'(a);
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_irq(input int limit, output int n);
    int i = 0;
    n = 0;
    while (n == 0 && i < limit) begin
      i++;
      @(negedge clk);
      if (irq) n = i;
    end
  endtask

  task automatic count_irq(input int cycles, output int seen);
    seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (irq) seen++;
    end
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    for (int a = 0; a < 16; a += 4) begin
      rd(a, d);
      check("R1 register after reset", d, 32'h0);
    end
  endtask

  task automatic t_period();
    logic [DW-1:0] d;
    wr(4, 32'h50);
    rd(4, d); check("R2 period readback stopped", d, 32'h50);
    wr(12, 32'h40); wr(0, 32'h3);
    rd(4, d); check("R2 period readback running", d, 32'h50);
    wr(0, 32'h8);
  endtask

  task automatic t_gate();
    logic [DW-1:0] d;
    int seen;
    wr(12, 32'h6); wr(0, 32'h1);
    count_irq(12, seen);
    rd(12, d); check("R3 count frozen with power only", d, 32'h6);
    check("R9 count independent of period", d, 32'h6);
    wr(0, 32'h2);
    count_irq(12, seen);
    check("R3 no pulse with run only", seen, 0);
    rd(12, d); check("R3 count frozen with run only", d, 32'h6);
    wr(0, 32'h8);
  endtask

  task automatic t_oneshot();
    logic [DW-1:0] d;
    int n, seen;
    wr(8, 32'h0); wr(12, 32'h5); wr(0, 32'h3);
    wait_irq(50, n);
    check("R4 expiry cycle scale 0", n, 5);
    @(negedge clk);
    check("R5 pulse lasts one cycle", {31'b0, irq}, 32'h0);
    rd(0, d);  check("R5 flag set, ctrl word", d, 32'h0B);
    rd(12, d); check("R7 count rests at zero", d, 32'h0);
    count_irq(20, seen);
    check("R7 no further pulses", seen, 0);
    rd(0, d);  check("R7 run bit kept", d, 32'h0B);
    wr(0, 32'h8);
  endtask

  task automatic t_prescale();
    int n;
    wr(8, 32'h2); wr(12, 32'h3); wr(0, 32'h3);
    wait_irq(80, n);
    check("R4 expiry cycle scale 2", n, 9);
    wr(0, 32'h8);
  endtask

  task automatic t_reload();
    logic [DW-1:0] d;
    int n;
    wr(8, 32'h0); wr(4, 32'h4); wr(12, 32'h2); wr(0, 32'h7);
    wait_irq(50, n);
    check("R4 first expiry with reload", n, 2);
    wait_irq(50, n);
    check("R6 reload interval", n, 4);
    rd(0, d); check("R6 ctrl word with reload", d, 32'h0F);
  endtask

  task automatic t_flag();
    logic [DW-1:0] d, c0, c1;
    wr(0, 32'h0);
    rd(0, d); check("R8 stop keeps flag", d, 32'h08);
    rd(12, c0); @(negedge clk); @(negedge clk); rd(12, c1);
    check("R3 count frozen after stop", c1, c0);
    wr(0, 32'h1);
    rd(0, d); check("R8 writing 0 to flag keeps it", d, 32'h09);
    wr(0, 32'h8);
    rd(0, d); check("R8 write one clears flag", d, 32'h00);
  endtask

  task automatic t_count_wr();
    logic [DW-1:0] d;
    wr(4, 32'h15); wr(0, 32'h1); wr(12, 32'h13);
    rd(12, d); check("R9 count written while disabled", d, 32'h13);
    rd(4, d);  check("R9 period untouched by count write", d, 32'h15);
    wr(0, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [DW-1:0] d, p, s, c;
    rd(4, p); rd(8, s); rd(12, c);
    wr(16, 32'hFFFF_FFFF); wr(2, 32'hF); wr(6, 32'h1234);
    rd(16, d); check("R10 offset 0x10 reads zero", d, 32'h0);
    rd(6, d);  check("R10 unaligned offset reads zero", d, 32'h0);
    rd(0, d);  check("R10 ctrl unchanged", d, 32'h0);
    rd(4, d);  check("R10 period unchanged", d, p);
    rd(8, d);  check("R10 scale unchanged", d, s);
    rd(12, d); check("R10 count unchanged", d, c);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_period();
    t_gate();
    t_oneshot();
    t_prescale();
    t_reload();
    t_flag();
    t_count_wr();
    t_unmapped();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog R1-R10 run actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule